// File: doc/BRIEF.md
# Packet-Slotted Capture Framer

This block takes a byte stream of captured samples and places it in memory as a ring of fixed-size slots. Each slot can be passed to a network stack without copying. Every slot starts on a 2048-byte boundary and opens with a 12-byte reserved area. Software fills that area with protocol headers later, so the block never writes it.

Right after the reserved area, the block writes a 16-bit sequence number, least significant byte first. A receiver uses this number to spot lost packets. The next 1498 sample bytes follow in arrival order. Once the last of them is written, the block raises a one-cycle completion pulse that carries the slot number. It then moves to the next slot boundary and leaves the tail of the finished slot untouched.

While it emits the two sequence bytes, the block holds its input ready low, so the upstream source waits and no sample is lost. Dropping the enable input abandons the slot in progress and restarts the layout at slot 0 with sequence number 0.

Top module: `slot_framer`

## Requirements
- R1: While `rst_n` is low or `en` is low, `in_ready` is 0. A write or completion pulse can appear in the cycle after `en` falls only when it is caused by a byte accepted before the fall. In the cycle after a reset, `wr_en`, `done` and `in_ready` are all 0.
- R2: Every write address is the slot number times 2048 plus the byte offset within the slot. The slot number sits in the address bits above bit 10.
- R3: Offsets 0 to 11 and offsets 1512 to 2047 of every slot are never written.
- R4: At the start of each slot, the sequence number is written at offsets 12 (bits 7:0) and 13 (bits 15:8) in two consecutive cycles. These two writes do not need any input byte.
- R5: The sequence number is 0 in the first slot after a reset or enable. It increases by one in each following slot and wraps modulo 65536.
- R6: Each byte accepted (`in_valid` and `in_ready` both high at a clock edge) is written exactly once, one cycle later. Accepted bytes fill offsets 14 to 1511 in order.
- R7: `in_ready` is 0 in the two cycles in which the sequence bytes are produced. It is 1 in every payload cycle while `en` is high.
- R8: `done` is high for exactly one cycle, in the same cycle as the write of the final payload byte (offset 1511). At that point `done_slot` gives the number of the slot just finished.
- R9: Slots are used in the order 0, 1, ..., NUM_SLOTS-1, and then 0 again.
- R10: If `en` goes low in the middle of a slot, the partial slot is dropped and no completion pulse is raised for it. A byte offered while `en` is low is not accepted. After `en` returns, writing restarts at slot 0, offset 12, with sequence number 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enable; low restarts the layout |
| in_valid | input | 1 | Sample byte offered |
| in_data | input | 8 | Sample byte |
| in_ready | output | 1 | Sample byte can be taken |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 13 | Byte address (slot, offset) |
| wr_data | output | 8 | Byte to write |
| done | output | 1 | One-cycle slot completion pulse |
| done_slot | output | 2 | Number of the finished slot |

## Verification
Two events meet in one cycle: acceptance of the final payload byte of a slot, and a fall of `en`. The bench offers the 1498th byte of a slot in the same cycle that it drops `en`. It then expects no write, no completion pulse, and a restart at slot 0 with sequence number 0.

The write of the last payload byte and its completion pulse also fall in one cycle. That same cycle is where the ring wraps from the last slot to slot 0. A reference model in the bench judges every write address, write data value and completion pulse, cycle by cycle.

// File: rtl/framer_pkg.sv
// Package: shared types for the slot framer.
// Assumes: byte-wide stream and byte-wide write port.
package framer_pkg;

    // Emission phase within one slot
    typedef enum logic [1:0] {
        PH_SEQ_LO = 2'd0,
        PH_SEQ_HI = 2'd1,
        PH_BODY   = 2'd2
    } phase_t;

    localparam int SEQ_W = 16;

endpackage

// File: rtl/framer_ring.sv
// Module: framer_ring
// Keeps the current slot number and the running sequence number.
// Both advance together when a slot completes and restart on reset or disable.
// Assumes: `advance` is a single-cycle pulse.
module framer_ring #(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       advance,
    output logic [SLOT_W-1:0]          slot,
    output logic [framer_pkg::SEQ_W-1:0] seq
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    // Slot ring position: steps on completion, wraps after the last entry
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            slot <= '0;
        end else if (advance) begin
            if (slot == LAST_SLOT) slot <= '0;
            else                   slot <= slot + 1'b1;
        end
    end

    // Sequence number: one step per completed slot, natural 16-bit wrap
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            seq <= '0;
        end else if (advance) begin
            seq <= seq + 1'b1;
        end
    end

endmodule

// File: rtl/framer_phase.sv
// Module: framer_phase
// Walks one slot: two sequence bytes, then PAYLOAD accepted sample bytes.
// Produces the in-slot offset of the byte emitted this cycle and the handshake.
// Assumes: HDR_GAP + 2 + PAYLOAD fits inside one slot.
module framer_phase #(
    parameter int SLOT_BYTES = 2048,
    parameter int HDR_GAP    = 12,
    parameter int PAYLOAD    = 1498,
    localparam int OFF_W     = $clog2(SLOT_BYTES),
    localparam int PAY_W     = $clog2(PAYLOAD)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    in_valid,
    output logic                    in_ready,
    output framer_pkg::phase_t      phase,
    output logic                    emit,
    output logic                    last,
    output logic [OFF_W-1:0]        offset
);

    import framer_pkg::*;

    localparam logic [PAY_W-1:0] PAY_LAST = PAY_W'(PAYLOAD - 1);
    localparam logic [OFF_W-1:0] OFF_LO   = OFF_W'(HDR_GAP);
    localparam logic [OFF_W-1:0] OFF_HI   = OFF_W'(HDR_GAP + 1);
    localparam logic [OFF_W-1:0] OFF_BODY = OFF_W'(HDR_GAP + 2);

    logic [PAY_W-1:0] pay_cnt;
    logic             take;

    // Handshake: samples are taken only in the body phase while enabled
    always_comb begin
        in_ready = en && (phase == PH_BODY);
        take     = in_ready && in_valid;
        emit     = en && ((phase != PH_BODY) || in_valid);
        last     = take && (pay_cnt == PAY_LAST);
    end

    // Offset of the byte emitted this cycle
    always_comb begin
        case (phase)
            PH_SEQ_LO: offset = OFF_LO;
            PH_SEQ_HI: offset = OFF_HI;
            default:   offset = OFF_BODY + OFF_W'(pay_cnt);
        endcase
    end

    // Phase sequencer: low counter byte, high counter byte, then payload
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase   <= PH_SEQ_LO;
            pay_cnt <= '0;
        end else begin
            case (phase)
                PH_SEQ_LO: phase <= PH_SEQ_HI;
                PH_SEQ_HI: begin
                    phase   <= PH_BODY;
                    pay_cnt <= '0;
                end
                default: begin
                    if (take) begin
                        if (pay_cnt == PAY_LAST) begin
                            phase   <= PH_SEQ_LO;
                            pay_cnt <= '0;
                        end else begin
                            pay_cnt <= pay_cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/framer_wport.sv
// Module: framer_wport
// Registers the write port and the completion pulse so that the pulse
// lines up with the write of the final payload byte.
// Assumes: slot size is a power of two, so the address is a concatenation.
module framer_wport #(
    parameter int SLOT_W = 2,
    parameter int OFF_W  = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    emit,
    input  logic                    last,
    input  logic [SLOT_W-1:0]       slot,
    input  logic [OFF_W-1:0]        offset,
    input  logic [7:0]              byte_in,
    output logic                    wr_en,
    output logic [SLOT_W+OFF_W-1:0] wr_addr,
    output logic [7:0]              wr_data,
    output logic                    done,
    output logic [SLOT_W-1:0]       done_slot
);

    // Output register stage; only reset clears it, so accepted bytes always land
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            done      <= 1'b0;
            done_slot <= '0;
        end else begin
            wr_en     <= emit;
            wr_addr   <= {slot, offset};
            wr_data   <= byte_in;
            done      <= last;
            done_slot <= slot;
        end
    end

endmodule

// File: rtl/slot_framer.sv
// Module: slot_framer (top)
// Lays sample bytes into a ring of slots: reserved header gap, 16-bit
// little-endian sequence number, fixed payload, one-cycle completion pulse.
// Assumes: SLOT_BYTES is a power of two and HDR_GAP+2+PAYLOAD <= SLOT_BYTES.
module slot_framer #(
    parameter int SLOT_BYTES = 2048,
    parameter int HDR_GAP    = 12,
    parameter int PAYLOAD    = 1498,
    parameter int NUM_SLOTS  = 4,
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int OFF_W     = $clog2(SLOT_BYTES),
    localparam int ADDR_W    = SLOT_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic [SLOT_W-1:0] done_slot
);

    import framer_pkg::*;

    phase_t             phase;
    logic               emit;
    logic               last;
    logic [OFF_W-1:0]   offset;
    logic [SLOT_W-1:0]  slot;
    logic [SEQ_W-1:0]   seq;
    logic [7:0]         byte_sel;

    framer_phase #(
        .SLOT_BYTES (SLOT_BYTES),
        .HDR_GAP    (HDR_GAP),
        .PAYLOAD    (PAYLOAD)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .phase    (phase),
        .emit     (emit),
        .last     (last),
        .offset   (offset)
    );

    framer_ring #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .advance (last),
        .slot    (slot),
        .seq     (seq)
    );

    // Byte source select: counter low, counter high, or sample byte
    always_comb begin
        case (phase)
            PH_SEQ_LO: byte_sel = seq[7:0];
            PH_SEQ_HI: byte_sel = seq[15:8];
            default:   byte_sel = in_data;
        endcase
    end

    framer_wport #(
        .SLOT_W (SLOT_W),
        .OFF_W  (OFF_W)
    ) u_wport (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit      (emit),
        .last      (last),
        .slot      (slot),
        .offset    (offset),
        .byte_in   (byte_sel),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .done      (done),
        .done_slot (done_slot)
    );

endmodule

// File: rtl/framer_checks.sv
// Module: framer_checks
// Port-level properties of slot_framer, attached with a bind.
// Assumes: same parameters as the bound instance.
module framer_checks #(
    parameter int SLOT_BYTES = 2048,
    parameter int HDR_GAP    = 12,
    parameter int PAYLOAD    = 1498,
    parameter int NUM_SLOTS  = 4,
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int OFF_W     = $clog2(SLOT_BYTES),
    localparam int ADDR_W    = SLOT_W + OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              in_ready,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              done
);

    logic [OFF_W-1:0] woff;
    assign woff = wr_addr[OFF_W-1:0];

    // R1: no handshake while disabled
    p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !in_ready);

    // R1: two disabled cycles in a row produce no write
    p_idle_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (en || !wr_en));

    // R3: writes stay out of the header gap and the unused tail
    p_gap_untouched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (woff >= OFF_W'(HDR_GAP)) && (woff < OFF_W'(HDR_GAP + 2 + PAYLOAD)));

    // R4: the high counter byte follows the low one in the next cycle
    p_seq_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && woff == OFF_W'(HDR_GAP) && en) |=> (wr_en && woff == OFF_W'(HDR_GAP + 1)));

    // R7: input is stalled while the next slot's counter is produced
    p_stall_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: completion coincides with the final payload write
    p_done_with_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_en && woff == OFF_W'(HDR_GAP + 1 + PAYLOAD)));

endmodule

bind slot_framer framer_checks #(
    .SLOT_BYTES (SLOT_BYTES),
    .HDR_GAP    (HDR_GAP),
    .PAYLOAD    (PAYLOAD),
    .NUM_SLOTS  (NUM_SLOTS)
) i_framer_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .done     (done)
);

// File: tb/test_slot_framer.sv
`timescale 1ns/1ps
module test_slot_framer;

    localparam int SLOT_BYTES = 2048;
    localparam int HDR_GAP    = 12;
    localparam int PAYLOAD    = 1498;
    localparam int NUM_SLOTS  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        wr_en;
    logic [12:0] wr_addr;
    logic [7:0]  wr_data;
    logic        done;
    logic [1:0]  done_slot;

    int n_checks = 0;
    int n_fails  = 0;
    bit mon_on   = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int          m_slot = 0;
    int          m_pos  = 0;
    int          m_seq  = 0;
    int          m_k    = 0;
    int          m_done_cnt = 0;
    int          k_drv  = 0;

    always #2 clk = ~clk;

    slot_framer i_slot_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .done      (done),
        .done_slot (done_slot)
    );

    function automatic logic [7:0] pat(int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    task automatic chk(bit ok, string tag, int got, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_restart();
        m_slot = 0;
        m_pos  = 0;
        m_seq  = 0;
    endtask

    // Reference model: judges every write, pulse and handshake at the falling edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (wr_en) begin
                int ea;
                int ed;
                bit is_last;
                ea = m_slot * SLOT_BYTES + HDR_GAP + m_pos;
                if (m_pos == 0)      ed = m_seq & 255;
                else if (m_pos == 1) ed = (m_seq >> 8) & 255;
                else                 ed = pat(m_k);
                is_last = (m_pos == PAYLOAD + 1);
                chk(wr_addr == 13'(ea), "R2/R3/R9 address", wr_addr, ea);
                if (m_pos < 2) chk(wr_data == 8'(ed), "R4/R5 sequence byte", wr_data, ed);
                else           chk(wr_data == 8'(ed), "R6 payload byte", wr_data, ed);
                chk(done == is_last, "R8 done with final write", done, is_last);
                if (is_last) chk(done_slot == 2'(m_slot), "R8 done_slot", done_slot, m_slot);
                if (m_pos >= 2) m_k++;
                m_pos++;
                if (is_last) begin
                    m_pos = 0;
                    m_seq = (m_seq + 1) & 16'hffff;
                    m_slot = (m_slot + 1) % NUM_SLOTS;
                    m_done_cnt++;
                end
            end else begin
                chk(!done, "R8 done without write", done, 0);
            end
            if (!en) begin
                model_restart();
                chk(!in_ready, "R1 ready while disabled", in_ready, 0);
            end else begin
                chk(in_ready == (m_pos >= 2), "R7 ready phase", in_ready, (m_pos >= 2));
            end
        end
    end

    // Drive n accepted bytes; gappy mode withholds valid in some cycles
    task automatic send(int n, bit gappy);
        int got = 0;
        int cyc = 0;
        while (got < n) begin
            in_valid = gappy ? ((cyc % 3) != 1) : 1'b1;
            in_data  = pat(k_drv);
            @(negedge clk);
            if (in_valid && in_ready) begin
                got++;
                k_drv++;
            end
            @(posedge clk);
            #1;
            cyc++;
        end
        in_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        en    = 1'b1;
        idle(3);
        @(negedge clk);
        chk(!wr_en && !done && !in_ready, "R1 reset outputs", {wr_en, done, in_ready}, 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_restart();
        mon_on = 1'b1;
    endtask

    // R6/R8: two slots of unbroken stream
    task automatic t_full();
        int d0 = m_done_cnt;
        send(2 * PAYLOAD, 1'b0);
        idle(3);
        chk(m_done_cnt - d0 == 2, "R8 two completions", m_done_cnt - d0, 2);
        chk(m_slot == 2, "R9 slot after two", m_slot, 2);
    endtask

    // R6/R7: stream with bubbles in valid
    task automatic t_gappy();
        int d0 = m_done_cnt;
        send(PAYLOAD, 1'b1);
        idle(3);
        chk(m_done_cnt - d0 == 1, "R6 one gappy slot", m_done_cnt - d0, 1);
    endtask

    // R9/R5: ring wraps from the last slot to slot 0, counter keeps rising
    task automatic t_wrap();
        send(2 * PAYLOAD, 1'b0);
        idle(3);
        chk(m_slot == 1, "R9 wrap to slot 0 then 1", m_slot, 1);
        chk(m_seq == 5, "R5 counter after five slots", m_seq, 5);
    endtask

    // R10: disable mid-slot and disable colliding with final byte
    task automatic t_disable();
        int d0;
        send(700, 1'b1);
        idle(2);
        en = 1'b0;
        @(negedge clk);
        chk(!in_ready, "R10 ready low on disable", in_ready, 0);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1;
            @(negedge clk);
            chk(!wr_en, "R10 no write while disabled", wr_en, 0);
        end
        @(posedge clk);
        #1;
        en = 1'b1;
        send(PAYLOAD - 1, 1'b0);
        d0 = m_done_cnt;
        in_valid = 1'b1;
        in_data  = pat(k_drv);
        en       = 1'b0;
        @(negedge clk);
        chk(!in_ready, "R10 final byte refused when disabled", in_ready, 0);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        @(negedge clk);
        chk(!wr_en && !done, "R10 no write or done after collision", {wr_en, done}, 0);
        chk(m_done_cnt == d0, "R10 partial slot dropped", m_done_cnt, d0);
        @(posedge clk);
        #1;
        en = 1'b1;
        send(PAYLOAD, 1'b0);
        idle(3);
        chk(m_done_cnt - d0 == 1, "R10 restart completes", m_done_cnt - d0, 1);
        chk(m_seq == 1 && m_slot == 1, "R10 restart at slot 0 seq 0", m_seq, 1);
    endtask

    initial begin
        #1;
        t_reset();
        t_full();
        t_gappy();
        t_wrap();
        t_disable();
        mon_on = 1'b0;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run is a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule